// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the processor-side front end of a three-channel interval timer. A host reaches it over an 8-bit data bus with a 2-bit address and separate single-cycle write and read strobes. Addresses 0, 1 and 2 reach the 16-bit count register of channels 0, 1 and 2. Address 3 takes control words. The block turns control words into per-channel settings. It splits each 16-bit count into byte transfers according to the channel's access mode, and it keeps one-shot snapshots of a channel's count and of its status.

The counting engines sit outside the block. Each engine gets a one-cycle load strobe with a 16-bit start value, plus its counting mode and decimal flag. In return each engine supplies its live count and its output level. A host freezes a count by writing a latch command, or uses a read-back command to snapshot count and status on several channels in one write. It then reads the frozen values byte by byte through the channel's count address.

Top module: `tmr_hostif`

## Requirements
- R1: After reset every channel is in access mode 3 (low byte then high byte), counting mode 3 and decimal flag 0, with no count or status snapshot pending.
- R2: A write to address 3 is a control word: bits 7:6 pick the channel, bits 5:4 the access mode, bits 3:1 the counting mode and bit 0 the decimal flag. A nonzero access field stores these settings for the channel and returns both its write and its read byte sequence to the low byte. The settings appear on the channel outputs one cycle after the write.
- R3: In access mode 1 a count write loads {8'h00, byte}. In access mode 2 it loads {byte, 8'h00}. The load strobe and value appear for exactly one cycle, on the cycle after the write.
- R4: In access mode 3 the first byte written is held and nothing is loaded. The second byte loads {second, first}. Reprogramming the channel drops a held first byte.
- R5: A control word with access field 0 snapshots the selected channel's live count at the write edge. Reads then return that snapshot instead of the live count: one byte (low for access mode 1, high for access mode 2), or low then high for access mode 3. The snapshot is released after its last byte.
- R6: A count snapshot request for a channel that already has a count snapshot pending is ignored.
- R7: A control word with bits 7:6 = 3 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 requests a count snapshot and bit 4 = 0 a status snapshot on every selected channel in the same cycle.
- R8: A status byte is {output level, 1'b0, access mode[1:0], counting mode[2:0], decimal flag}, captured at the command edge. A status request on a channel whose status is still pending is ignored.
- R9: A read returns a pending status byte first and releases it. Otherwise it returns a pending count snapshot byte. Otherwise it returns the live count.
- R10: With nothing pending, a live read returns the low byte in access mode 1, the high byte in access mode 2, and alternately low then high in access mode 3.
- R11: Read data is valid combinationally while the read strobe is high. Read-side state advances at the clock edge that ends the strobe. A read of address 3 returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address: 0..2 channel count, 3 control |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | One-cycle write strobe |
| bus_rd | input | 1 | One-cycle read strobe |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| ch_live | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| ch_out | input | 3 | Output level of each channel |
| ch_load | output | 3 | One-cycle load strobe per channel |
| ch_load_val | output | 48 | Start value per channel, channel n at bits 16n+15:16n |
| ch_mode | output | 9 | Counting mode per channel, channel n at bits 3n+2:3n |
| ch_decimal | output | 3 | Decimal flag per channel |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it a quarter period before the edge that advances the read state. Load strobes, load values and the channel settings are due one cycle after the write, so a reference model updates its prediction at the moment it drives the write. A monitor then compares that prediction with all channel outputs a quarter period after every rising edge. Snapshots take the live count and output level present at the command edge. The bench therefore changes those inputs only in cycles without a command, so a wrong capture cycle shows up as a wrong byte.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 2;
  localparam int N_CH   = (1 << ADDR_W) - 1;
  localparam int MODE_W = 3;
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(N_CH);
  localparam logic [1:0] RB_SEL = 2'b11;
  localparam int RB_NOCNT_BIT = 5;
  localparam int RB_NOSTS_BIT = 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_LOHI  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [1:0]        sel;
    acc_e              acc;
    logic [MODE_W-1:0] mode;
    logic              bcd;
  } ctl_word_t;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [CNT_W-1:0] v,
                                                  input logic hi);
    return hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] load_value(input acc_e acc,
                                                  input logic [BYTE_W-1:0] held,
                                                  input logic [BYTE_W-1:0] b);
    case (acc)
      ACC_LO:  return {{BYTE_W{1'b0}}, b};
      ACC_HI:  return {b, {BYTE_W{1'b0}}};
      default: return {b, held};
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] status_byte(input logic out,
                                                    input acc_e acc,
                                                    input logic [MODE_W-1:0] mode,
                                                    input logic bcd);
    return {out, 1'b0, acc, mode, bcd};
  endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [N_CH-1:0]   prog_o,
  output logic [N_CH-1:0]   cnt_req_o,
  output logic [N_CH-1:0]   sts_req_o,
  output logic [N_CH-1:0]   data_wr_o,
  output logic [N_CH-1:0]   data_rd_o,
  output acc_e              acc_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o
);
  ctl_word_t cw;
  logic      ctl_wr;
  logic      readback;

  assign cw       = ctl_word_t'(wdata_i);
  assign ctl_wr   = wr_i && (addr_i == CTL_ADDR);
  assign readback = (cw.sel == RB_SEL);
  assign acc_o    = cw.acc;
  assign mode_o   = cw.mode;
  assign bcd_o    = cw.bcd;

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    logic hit_sel;
    logic rb_pick;
    assign hit_sel      = !readback && (cw.sel == 2'(i));
    assign rb_pick      = readback && wdata_i[i+1];
    assign prog_o[i]    = ctl_wr && hit_sel && (cw.acc != ACC_LATCH);
    assign cnt_req_o[i] = ctl_wr && ((hit_sel && (cw.acc == ACC_LATCH)) ||
                                     (rb_pick && !wdata_i[RB_NOCNT_BIT]));
    assign sts_req_o[i] = ctl_wr && rb_pick && !wdata_i[RB_NOSTS_BIT];
    assign data_wr_o[i] = wr_i && (addr_i == ADDR_W'(i));
    assign data_rd_o[i] = rd_i && (addr_i == ADDR_W'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_i,
  input  acc_e              prog_acc_i,
  input  logic [MODE_W-1:0] prog_mode_i,
  input  logic              prog_bcd_i,
  input  logic              cnt_req_i,
  input  logic              sts_req_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  live_i,
  input  logic              out_i,
  output logic [BYTE_W-1:0] rbyte_o,
  output logic              ld_stb_o,
  output logic [CNT_W-1:0]  ld_val_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              bcd_o
);
  acc_e              acc_q;
  logic [MODE_W-1:0] mode_q;
  logic              bcd_q;
  logic              wr_hi_q;
  logic [BYTE_W-1:0] held_q;
  logic              rd_hi_q;
  acc_e              cpend_q;
  logic [CNT_W-1:0]  cval_q;
  logic              spend_q;
  logic [BYTE_W-1:0] sval_q;

  // named internal events
  logic cnt_capture, sts_capture, rd_sts, rd_cnt, rd_live, load_now, hold_first;
  assign cnt_capture = cnt_req_i && (cpend_q == ACC_LATCH);
  assign sts_capture = sts_req_i && !spend_q;
  assign rd_sts      = rd_i && spend_q;
  assign rd_cnt      = rd_i && !spend_q && (cpend_q != ACC_LATCH);
  assign rd_live     = rd_i && !spend_q && (cpend_q == ACC_LATCH);
  assign hold_first  = wr_i && (acc_q == ACC_LOHI) && !wr_hi_q;
  assign load_now    = wr_i && !hold_first;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= ACC_LOHI;
      mode_q   <= MODE_W'(3);
      bcd_q    <= 1'b0;
      wr_hi_q  <= 1'b0;
      held_q   <= '0;
      rd_hi_q  <= 1'b0;
      cpend_q  <= ACC_LATCH;
      cval_q   <= '0;
      spend_q  <= 1'b0;
      sval_q   <= '0;
      ld_stb_o <= 1'b0;
      ld_val_o <= '0;
    end else begin
      ld_stb_o <= load_now;
      if (load_now) ld_val_o <= load_value(acc_q, held_q, wdata_i);
      if (hold_first) begin
        held_q  <= wdata_i;
        wr_hi_q <= 1'b1;
      end else if (load_now) begin
        wr_hi_q <= 1'b0;
      end
      if (rd_live && (acc_q == ACC_LOHI)) rd_hi_q <= !rd_hi_q;
      if (prog_i) begin
        acc_q   <= prog_acc_i;
        mode_q  <= prog_mode_i;
        bcd_q   <= prog_bcd_i;
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (cnt_capture) begin
        cpend_q <= acc_q;
        cval_q  <= live_i;
      end else if (rd_cnt) begin
        cpend_q <= (cpend_q == ACC_LOHI) ? ACC_HI : ACC_LATCH;
      end
      if (sts_capture) begin
        spend_q <= 1'b1;
        sval_q  <= status_byte(out_i, acc_q, mode_q, bcd_q);
      end else if (rd_sts) begin
        spend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (spend_q)
      rbyte_o = sval_q;
    else if (cpend_q != ACC_LATCH)
      rbyte_o = pick_byte(cval_q, cpend_q == ACC_HI);
    else
      rbyte_o = pick_byte(live_i, (acc_q == ACC_HI) || ((acc_q == ACC_LOHI) && rd_hi_q));
  end

  assign mode_o = mode_q;
  assign bcd_o  = bcd_q;

  a_r3_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb_o |-> $past(wr_i));
  a_r4_first_byte_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (acc_q == ACC_LOHI) && !wr_hi_q) |=> !ld_stb_o);
  a_r6_count_snapshot_held: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpend_q != ACC_LATCH) && !rd_i) |=> ($stable(cval_q) && $stable(cpend_q)));
  a_r8_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    (spend_q && !rd_i) |=> (spend_q && $stable(sval_q)));
  a_r9_status_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && spend_q && !sts_req_i && !cnt_req_i) |=> (!spend_q && $stable(cpend_q)));
  a_r5_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cnt && (cpend_q == ACC_LOHI) && !cnt_req_i) |=> (cpend_q == ACC_HI));
endmodule

// File: rtl/tmr_rd_select.sv
module tmr_rd_select
  import tmr_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] bytes_i [N_CH],
  output logic [BYTE_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_CH; i++)
      if (addr_i == ADDR_W'(i)) rdata_o = bytes_i[i];
  end
endmodule

// File: rtl/tmr_hostif.sv
module tmr_hostif
  import tmr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BYTE_W-1:0]       bus_wdata,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  output logic [BYTE_W-1:0]       bus_rdata,
  input  logic [N_CH*CNT_W-1:0]   ch_live,
  input  logic [N_CH-1:0]         ch_out,
  output logic [N_CH-1:0]         ch_load,
  output logic [N_CH*CNT_W-1:0]   ch_load_val,
  output logic [N_CH*MODE_W-1:0]  ch_mode,
  output logic [N_CH-1:0]         ch_decimal
);
  logic [N_CH-1:0]   prog, cnt_req, sts_req, data_wr, data_rd;
  acc_e              dec_acc;
  logic [MODE_W-1:0] dec_mode;
  logic              dec_bcd;
  logic [BYTE_W-1:0] rbytes [N_CH];

  tmr_ctl_decode u_dec (
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .wr_i      (bus_wr),
    .rd_i      (bus_rd),
    .prog_o    (prog),
    .cnt_req_o (cnt_req),
    .sts_req_o (sts_req),
    .data_wr_o (data_wr),
    .data_rd_o (data_rd),
    .acc_o     (dec_acc),
    .mode_o    (dec_mode),
    .bcd_o     (dec_bcd)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    tmr_chan_regs u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .prog_i      (prog[i]),
      .prog_acc_i  (dec_acc),
      .prog_mode_i (dec_mode),
      .prog_bcd_i  (dec_bcd),
      .cnt_req_i   (cnt_req[i]),
      .sts_req_i   (sts_req[i]),
      .wr_i        (data_wr[i]),
      .rd_i        (data_rd[i]),
      .wdata_i     (bus_wdata),
      .live_i      (ch_live[i*CNT_W +: CNT_W]),
      .out_i       (ch_out[i]),
      .rbyte_o     (rbytes[i]),
      .ld_stb_o    (ch_load[i]),
      .ld_val_o    (ch_load_val[i*CNT_W +: CNT_W]),
      .mode_o      (ch_mode[i*MODE_W +: MODE_W]),
      .bcd_o       (ch_decimal[i])
    );
  end

  tmr_rd_select u_rd (
    .addr_i  (bus_addr),
    .bytes_i (rbytes),
    .rdata_o (bus_rdata)
  );

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_wr | prog));
  a_r11_ctl_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == CTL_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/tmr_hostif_test.sv
module tmr_hostif_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [47:0] ch_live = '0;
  logic [2:0]  ch_out = '0;
  logic [2:0]  ch_load;
  logic [47:0] ch_load_val;
  logic [8:0]  ch_mode;
  logic [2:0]  ch_decimal;

  int checks = 0;
  int errors = 0;
  bit running = 0;
  bit done = 0;

  // reference model
  int m_acc[3], m_mode[3], m_bcd[3], m_whi[3], m_hold[3], m_rhi[3];
  int m_cp[3], m_cv[3], m_sp[3], m_sv[3];
  bit [2:0] exp_ld;
  int exp_val[3];

  tmr_hostif uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ch_live(ch_live),
    .ch_out(ch_out), .ch_load(ch_load), .ch_load_val(ch_load_val),
    .ch_mode(ch_mode), .ch_decimal(ch_decimal)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #(PERIOD/4);
    if (running) begin
      for (int c = 0; c < 3; c++) begin
        chk("R2 mode output", int'(ch_mode[c*3 +: 3]), m_mode[c]);
        chk("R2 decimal output", int'(ch_decimal[c]), m_bcd[c]);
        chk("R3 R4 load strobe", int'(ch_load[c]), int'(exp_ld[c]));
        if (exp_ld[c]) chk("R3 R4 load value", int'(ch_load_val[c*16 +: 16]), exp_val[c]);
      end
    end
  end

  task automatic start_cycle();
    @(negedge clk);
    bus_wr = 1'b0;
    bus_rd = 1'b0;
    exp_ld = '0;
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) start_cycle();
  endtask

  task automatic set_live(int c, int v, bit o);
    start_cycle();
    ch_live[c*16 +: 16] = 16'(v);
    ch_out[c] = o;
  endtask

  task automatic wr(int a, int d);
    int sel, acc, lv;
    start_cycle();
    bus_addr = 2'(a);
    bus_wdata = 8'(d);
    bus_wr = 1'b1;
    if (a == 3) begin
      sel = (d >> 6) & 3;
      acc = (d >> 4) & 3;
      if (sel == 3) begin
        for (int c = 0; c < 3; c++) begin
          if ((d >> (c + 1)) & 1) begin
            lv = int'(ch_live[c*16 +: 16]);
            if (!((d >> 5) & 1) && m_cp[c] == 0) begin m_cp[c] = m_acc[c]; m_cv[c] = lv; end
            if (!((d >> 4) & 1) && m_sp[c] == 0) begin
              m_sv[c] = (int'(ch_out[c]) << 7) | (m_acc[c] << 4) | (m_mode[c] << 1) | m_bcd[c];
              m_sp[c] = 1;
            end
          end
        end
      end else if (acc == 0) begin
        if (m_cp[sel] == 0) begin m_cp[sel] = m_acc[sel]; m_cv[sel] = int'(ch_live[sel*16 +: 16]); end
      end else begin
        m_acc[sel] = acc; m_mode[sel] = (d >> 1) & 7; m_bcd[sel] = d & 1;
        m_whi[sel] = 0; m_rhi[sel] = 0;
      end
    end else begin
      case (m_acc[a])
        1: begin exp_ld[a] = 1; exp_val[a] = d; end
        2: begin exp_ld[a] = 1; exp_val[a] = d << 8; end
        default:
          if (m_whi[a] == 0) begin m_hold[a] = d; m_whi[a] = 1; end
          else begin exp_ld[a] = 1; exp_val[a] = (d << 8) | m_hold[a]; m_whi[a] = 0; end
      endcase
    end
  endtask

  task automatic rd(int a, string tag);
    int e, lv;
    start_cycle();
    bus_addr = 2'(a);
    bus_rd = 1'b1;
    #(PERIOD/4);
    if (a == 3) e = 0;
    else if (m_sp[a]) begin e = m_sv[a]; m_sp[a] = 0; end
    else if (m_cp[a] != 0) begin
      if (m_cp[a] == 2) begin e = (m_cv[a] >> 8) & 255; m_cp[a] = 0; end
      else if (m_cp[a] == 1) begin e = m_cv[a] & 255; m_cp[a] = 0; end
      else begin e = m_cv[a] & 255; m_cp[a] = 2; end
    end else begin
      lv = int'(ch_live[a*16 +: 16]);
      if (m_acc[a] == 2 || (m_acc[a] == 3 && m_rhi[a] == 1)) e = (lv >> 8) & 255;
      else e = lv & 255;
      if (m_acc[a] == 3) m_rhi[a] = 1 - m_rhi[a];
    end
    chk(tag, int'(bus_rdata), e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) begin
      m_acc[c] = 3; m_mode[c] = 3; m_bcd[c] = 0; m_whi[c] = 0; m_hold[c] = 0;
      m_rhi[c] = 0; m_cp[c] = 0; m_cv[c] = 0; m_sp[c] = 0; m_sv[c] = 0; exp_val[c] = 0;
    end
    exp_ld = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;
    idle(1);
    chk("R1 reset modes", int'(ch_mode), 9'o333);
    chk("R1 reset load idle", int'(ch_load), 0);
    // R1 R10: reset access mode reads low then high
    set_live(0, 16'h1234, 1'b0);
    rd(0, "R1 R10 live low");
    rd(0, "R1 R10 live high");
    // R2 R3: channel 1 low-only, mode 2, decimal set
    wr(3, 8'h55);
    wr(1, 8'hAB);
    set_live(1, 16'h5678, 1'b0);
    rd(1, "R10 low only");
    rd(1, "R10 low only again");
    // R3: channel 2 high-only, mode 0
    wr(3, 8'hA0);
    wr(2, 8'hCD);
    set_live(2, 16'h9ABC, 1'b1);
    rd(2, "R10 high only");
    // R4: channel 0 low-then-high, mode 4
    wr(3, 8'h38);
    wr(0, 8'h11);
    wr(0, 8'h22);
    wr(0, 8'h33);
    wr(3, 8'h38);
    wr(0, 8'h44);
    wr(0, 8'h55);
    // R5 R6: count snapshot on channel 0, second request ignored
    set_live(0, 16'hBEEF, 1'b1);
    wr(3, 8'h00);
    set_live(0, 16'h0001, 1'b1);
    wr(3, 8'h00);
    rd(0, "R5 R6 snapshot low");
    rd(0, "R5 R6 snapshot high");
    rd(0, "R9 live after snapshot");
    rd(0, "R10 live high");
    // R5: snapshot on a low-only channel is one byte
    set_live(1, 16'h4321, 1'b0);
    wr(3, 8'h40);
    set_live(1, 16'h0F0F, 1'b0);
    rd(1, "R5 one-byte snapshot");
    rd(1, "R5 released");
    // R7 R8 R9: read-back of channels 0 and 2, count and status
    set_live(0, 16'h0A0B, 1'b1);
    set_live(2, 16'h0C0D, 1'b1);
    wr(3, 8'hCA);
    set_live(0, 16'hFFFF, 1'b0);
    set_live(2, 16'hEEEE, 1'b0);
    rd(0, "R8 R9 status ch0");
    rd(0, "R7 R9 count low ch0");
    rd(0, "R7 count high ch0");
    rd(2, "R8 R9 status ch2");
    rd(2, "R7 count ch2");
    rd(2, "R10 live ch2");
    // R8: pending status not replaced
    set_live(1, 16'h2222, 1'b0);
    wr(3, 8'hE4);
    set_live(1, 16'h2222, 1'b1);
    wr(3, 8'hE4);
    rd(1, "R8 status kept");
    rd(1, "R9 live after status");
    // R7: count-only read-back of channel 0
    set_live(0, 16'h7788, 1'b1);
    wr(3, 8'hD2);
    set_live(0, 16'h0000, 1'b1);
    // R11: control address read returns 0 and changes nothing
    rd(3, "R11 control read");
    rd(0, "R7 R11 count low");
    rd(0, "R7 count high");
    rd(0, "R10 live low");
    idle(2);
    running = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule